// File: doc/BRIEF.md
# Threshold-Driven FIFO Service Requester

This block holds a small byte FIFO between a media-side byte stream and a host bus. It raises a service request toward the host whenever the FIFO needs attention. A single configuration bit picks the direction. In the read direction the media fills the FIFO and the host empties it. In the write direction the host fills it and the media drains it. A second bit picks how the host is served. With DMA, one request line is used, qualified by acknowledge and terminal-count inputs. Without DMA, an interrupt line and a polled ready bit move together.

The request points depend on occupancy and on a 4-bit threshold field. The effective threshold is the field plus one. In the read direction the request rises once the FIFO has filled to within that many entries of full, or when the final byte of a sector arrives. It stays up until the FIFO is empty. In the write direction the request rises when the execution phase starts and falls when the FIFO is full. It rises again once occupancy has fallen to the threshold. With the FIFO disabled, the store acts as a single byte, so every byte raises its own request. A pulse on `exec_start` begins a new execution phase: it empties the FIFO and clears every flag.

The media side uses valid/ready streams. On `dev_in`, a byte moves when valid and ready are both high. Ready is low in the write direction and whenever the store is full. A source that sees ready low must hold its byte and valid. On `dev_out`, valid is high in the write direction whenever the store holds data. The head byte on `dev_out_data` stays stable until ready is seen, and the sink may hold ready low for as long as it likes. Host strobes are single-cycle and are not back-pressured. A strobe that cannot be served is dropped and flagged.

Top module: `fifo_svc_req`

## Requirements
- R1: After reset, `irq`, `rqm`, `dma_req`, `result_phase`, `ovr_flag` and `udr_flag` are all low and `dev_out_valid` is low.
- R2: In the read direction with the FIFO enabled, the request becomes high in the cycle after the write that brings occupancy to 15 minus the threshold field (16 minus the effective threshold), with a floor of one byte.
- R3: In the read direction, a raised request stays high while the host drains the FIFO and goes low in the cycle after the read that empties it.
- R4: In the read direction, a media byte that arrives with `sector_last` high raises the request even when occupancy is below the trigger level.
- R5: In the write direction, `exec_start` raises the request. The request falls after the write that fills all 16 entries, and rises again after the drain that brings occupancy down to the threshold field plus one.
- R6: With `cfg_fifo_en` low, the store holds one byte. In the read direction each byte raises a request and the read of that byte drops it. In the write direction the request drops after one write and returns after that byte is drained.
- R7: With `cfg_dma_mode` low, `irq` and `rqm` are equal and `dma_req` stays low. With it high, only `dma_req` is driven.
- R8: In DMA write transfers, `dma_tc` and `dma_ack` high together drop `dma_req` in the next cycle, and it stays low until the next `exec_start`.
- R9: In DMA mode, with `xfer_last` high, a rising edge of `dma_ack` drops the request for the rest of the phase. A host strobe while `dma_ack` is low does the same.
- R10: In non-DMA write transfers, once `dma_tc` has been seen high, the first cycle with both `dma_tc` and `dma_ack` low clears `irq` for the rest of the phase.
- R11: In the write direction, `result_phase` rises once the host's final byte has been marked (by `xfer_last` on a write, or by terminal count) and the FIFO is empty. It stays high until `exec_start`.
- R12: A host write to a full FIFO and a host read of an empty FIFO are dropped and leave the stored data untouched. They set the sticky `ovr_flag` or `udr_flag`, which `exec_start` clears.
- R13: A push and a pop in the same cycle leave occupancy unchanged, and bytes leave in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_en | input | 1 | 1: 16-entry FIFO; 0: single-byte store |
| cfg_dma_mode | input | 1 | 1: DMA request line; 0: interrupt plus polled bit |
| cfg_dir_wr | input | 1 | 1: host-to-media; 0: media-to-host |
| cfg_thresh | input | 4 | Threshold field; effective threshold is field+1 |
| exec_start | input | 1 | Start of an execution phase; flushes FIFO, clears flags |
| sector_last | input | 1 | Qualifies a `dev_in` byte as the last of a sector |
| dev_in_valid | input | 1 | Media byte valid (read direction) |
| dev_in_ready | output | 1 | FIFO can accept a media byte |
| dev_in_data | input | 8 | Media byte |
| dev_out_valid | output | 1 | FIFO has a byte for the media (write direction) |
| dev_out_ready | input | 1 | Media takes the head byte |
| dev_out_data | output | 8 | Head byte toward the media |
| host_rd_stb | input | 1 | Host read strobe, one cycle per byte |
| host_wr_stb | input | 1 | Host write strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Head byte toward the host |
| xfer_last | input | 1 | Marks the current host byte as the final one |
| dma_ack | input | 1 | DMA acknowledge, active high |
| dma_tc | input | 1 | Terminal count, active high |
| dma_req | output | 1 | DMA service request |
| irq | output | 1 | Interrupt service request |
| rqm | output | 1 | Polled ready-for-transfer bit |
| result_phase | output | 1 | Write transfer complete; enter result phase |
| ovr_flag | output | 1 | Sticky: host write hit a full FIFO |
| udr_flag | output | 1 | Sticky: host read hit an empty FIFO |

## Verification
The read-direction trigger is swept over several threshold fields by one table-driven loop. Each fill checks the exact byte at which the request appears, and each drain checks that it holds until the store is empty. A skew of one between the field and the effective threshold shows up as a request one byte early or late. Directed sequences then cover the other cases. The sector-end flush is checked below the trigger level. The write-direction full drop and refill are checked at the refill boundary. The single-byte disabled mode is checked in both directions. Terminal count is checked in both service styles, last-byte acknowledge is checked both by an acknowledge edge and by a strobe alone, and a simultaneous push and pop is checked by the byte count at which the request next rises.

// File: rtl/svc_pkg.sv
package svc_pkg;

  typedef struct packed {
    logic fifo_en;
    logic dma_mode;
    logic dir_wr;
  } svc_cfg_t;

endpackage

// File: rtl/svc_fifo_store.sv
module svc_fifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     occ
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      occ <= occ + CW'(push) - CW'(pop);
    end
  end

  assign rdata = mem[rd_ptr];

endmodule

// File: rtl/svc_port_route.sv
module svc_port_route
  import svc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  svc_cfg_t          cfg,
  input  logic              exec_start,
  input  logic [CW-1:0]     occ,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  input  logic              sector_last,
  input  logic              dev_out_ready,
  input  logic              host_rd_stb,
  input  logic              host_wr_stb,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              xfer_last,
  output logic              push,
  output logic              pop,
  output logic [DATA_W-1:0] push_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic              sector_flush,
  output logic              wr_last,
  output logic              host_stb,
  output logic              ovr_flag,
  output logic              udr_flag
);

  logic [CW-1:0] cap;
  logic          at_cap, is_empty;

  always_comb begin
    cap      = cfg.fifo_en ? CW'(DEPTH) : CW'(1);
    at_cap   = (occ >= cap);
    is_empty = (occ == '0);

    dev_in_ready  = !cfg.dir_wr && !at_cap;
    dev_out_valid = cfg.dir_wr && !is_empty;

    if (cfg.dir_wr) begin
      push      = host_wr_stb && !at_cap;
      push_data = host_wdata;
      pop       = dev_out_ready && !is_empty;
      host_stb  = host_wr_stb;
    end else begin
      push      = dev_in_valid && !at_cap;
      push_data = dev_in_data;
      pop       = host_rd_stb && !is_empty;
      host_stb  = host_rd_stb;
    end

    sector_flush = !cfg.dir_wr && push && sector_last;
    wr_last      = cfg.dir_wr && push && xfer_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || exec_start) begin
      ovr_flag <= 1'b0;
      udr_flag <= 1'b0;
    end else begin
      if (cfg.dir_wr && host_wr_stb && at_cap)    ovr_flag <= 1'b1;
      if (!cfg.dir_wr && host_rd_stb && is_empty) udr_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/svc_req_ctrl.sv
module svc_req_ctrl
  import svc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  svc_cfg_t      cfg,
  input  logic [TW-1:0] thr_field,
  input  logic          exec_start,
  input  logic [CW-1:0] occ,
  input  logic          push,
  input  logic          pop,
  input  logic          sector_flush,
  input  logic          wr_last,
  input  logic          host_stb,
  input  logic          xfer_last,
  input  logic          dma_ack,
  input  logic          dma_tc,
  output logic          req,
  output logic          result_phase
);

  logic          active, fin, tc_seen, host_done, ack_q;
  logic          fin_nx, tc_seen_nx, host_done_nx, req_nx, result_nx;
  logic [CW-1:0] thr, occ_nx, cap, trig, refill;
  logic          last_hit, tc_dma_hit, tc_end;

  always_comb begin
    thr    = CW'(thr_field) + 1'b1;
    occ_nx = exec_start ? '0 : occ + CW'(push) - CW'(pop);
    cap    = cfg.fifo_en ? CW'(DEPTH) : CW'(1);
    trig   = cfg.fifo_en ? CW'(DEPTH) - thr : CW'(1);
    refill = cfg.fifo_en ? thr : '0;

    last_hit   = cfg.dma_mode && xfer_last &&
                 ((dma_ack && !ack_q) || (host_stb && !dma_ack));
    tc_dma_hit = cfg.dma_mode && cfg.dir_wr && dma_tc && dma_ack;
    tc_end     = !cfg.dma_mode && cfg.dir_wr && tc_seen && !dma_tc && !dma_ack;

    fin_nx       = !exec_start &&
                   (fin || (active && (last_hit || tc_dma_hit || tc_end)));
    tc_seen_nx   = !exec_start &&
                   (tc_seen || (active && !cfg.dma_mode && cfg.dir_wr && dma_tc));
    host_done_nx = !exec_start &&
                   (host_done ||
                    (active && cfg.dir_wr && (wr_last || tc_dma_hit || tc_end)));

    if (exec_start)           req_nx = cfg.dir_wr;
    else if (!active || fin_nx) req_nx = 1'b0;
    else if (cfg.dir_wr) begin
      if (occ_nx >= cap)         req_nx = 1'b0;
      else if (occ_nx <= refill) req_nx = 1'b1;
      else                       req_nx = req;
    end else begin
      if (occ_nx == '0)                        req_nx = 1'b0;
      else if (occ_nx >= trig || sector_flush) req_nx = 1'b1;
      else                                     req_nx = req;
    end

    result_nx = !exec_start &&
                (result_phase ||
                 (active && cfg.dir_wr && host_done_nx && occ_nx == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active       <= 1'b0;
      fin          <= 1'b0;
      tc_seen      <= 1'b0;
      host_done    <= 1'b0;
      ack_q        <= 1'b0;
      req          <= 1'b0;
      result_phase <= 1'b0;
    end else begin
      active       <= active || exec_start;
      fin          <= fin_nx;
      tc_seen      <= tc_seen_nx;
      host_done    <= host_done_nx;
      ack_q        <= dma_ack;
      req          <= req_nx;
      result_phase <= result_nx;
    end
  end

endmodule

// File: rtl/fifo_svc_req.sv
module fifo_svc_req
  import svc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fifo_en,
  input  logic              cfg_dma_mode,
  input  logic              cfg_dir_wr,
  input  logic [TW-1:0]     cfg_thresh,
  input  logic              exec_start,
  input  logic              sector_last,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              host_rd_stb,
  input  logic              host_wr_stb,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              xfer_last,
  input  logic              dma_ack,
  input  logic              dma_tc,
  output logic              dma_req,
  output logic              irq,
  output logic              rqm,
  output logic              result_phase,
  output logic              ovr_flag,
  output logic              udr_flag
);

  svc_cfg_t          cfg;
  logic              push, pop, sector_flush, wr_last, host_stb, req;
  logic [DATA_W-1:0] push_data, head;
  logic [CW-1:0]     occ;

  assign cfg = '{fifo_en: cfg_fifo_en, dma_mode: cfg_dma_mode, dir_wr: cfg_dir_wr};

  svc_port_route #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_route (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .exec_start(exec_start), .occ(occ),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .sector_last(sector_last), .dev_out_ready(dev_out_ready),
    .host_rd_stb(host_rd_stb), .host_wr_stb(host_wr_stb),
    .host_wdata(host_wdata), .xfer_last(xfer_last),
    .push(push), .pop(pop), .push_data(push_data),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .sector_flush(sector_flush), .wr_last(wr_last), .host_stb(host_stb),
    .ovr_flag(ovr_flag), .udr_flag(udr_flag)
  );

  svc_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(exec_start),
    .push(push), .wdata(push_data), .pop(pop), .rdata(head), .occ(occ)
  );

  svc_req_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .thr_field(cfg_thresh),
    .exec_start(exec_start), .occ(occ), .push(push), .pop(pop),
    .sector_flush(sector_flush), .wr_last(wr_last), .host_stb(host_stb),
    .xfer_last(xfer_last), .dma_ack(dma_ack), .dma_tc(dma_tc),
    .req(req), .result_phase(result_phase)
  );

  assign host_rdata   = head;
  assign dev_out_data = head;
  assign dma_req      = req && cfg_dma_mode;
  assign irq          = req && !cfg_dma_mode;
  assign rqm          = req && !cfg_dma_mode;

endmodule

// File: rtl/svc_req_chk.sv
module svc_req_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_fifo_en,
  input logic          cfg_dma_mode,
  input logic          cfg_dir_wr,
  input logic          exec_start,
  input logic          xfer_last,
  input logic          dma_ack,
  input logic          dma_tc,
  input logic          dma_req,
  input logic          irq,
  input logic          result_phase,
  input logic          ovr_flag,
  input logic          udr_flag,
  input logic [CW-1:0] occ
);

  // R3
  rd_empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dir_wr && $stable(cfg_dir_wr) && occ == '0) |-> !(irq || dma_req));

  // R5
  wr_full_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir_wr && cfg_fifo_en && $stable(cfg_dir_wr) && $stable(cfg_fifo_en)
     && occ == CW'(DEPTH)) |-> !(irq || dma_req));

  // R8
  tc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dma_mode && cfg_dir_wr && dma_tc && dma_ack && !exec_start) |=> !dma_req);

  // R9
  last_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dma_mode && xfer_last && $rose(dma_ack) && !exec_start) |=> !dma_req);

  // R11
  result_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_phase) |-> occ == '0);

  // R12
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !exec_start) |=> ovr_flag);

  // R12
  udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_flag && !exec_start) |=> udr_flag);

  // R13
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

endmodule

bind fifo_svc_req svc_req_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en),
  .cfg_dma_mode(cfg_dma_mode), .cfg_dir_wr(cfg_dir_wr),
  .exec_start(exec_start), .xfer_last(xfer_last), .dma_ack(dma_ack),
  .dma_tc(dma_tc), .dma_req(dma_req), .irq(irq),
  .result_phase(result_phase), .ovr_flag(ovr_flag), .udr_flag(udr_flag),
  .occ(occ)
);

// File: tb/sim_fifo_svc_req.sv
`timescale 1ns/1ps
module sim_fifo_svc_req;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_fifo_en = 1'b0, cfg_dma_mode = 1'b0, cfg_dir_wr = 1'b0;
  logic [3:0] cfg_thresh = '0;
  logic exec_start = 1'b0, sector_last = 1'b0;
  logic dev_in_valid = 1'b0, dev_out_ready = 1'b0;
  logic [7:0] dev_in_data = '0, host_wdata = '0;
  logic host_rd_stb = 1'b0, host_wr_stb = 1'b0, xfer_last = 1'b0;
  logic dma_ack = 1'b0, dma_tc = 1'b0;
  logic dev_in_ready, dev_out_valid, dma_req, irq, rqm;
  logic result_phase, ovr_flag, udr_flag;
  logic [7:0] dev_out_data, host_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fifo_svc_req u0 (.*);

  // {threshold field, expected trigger occupancy}
  localparam logic [8:0] RD_VEC [0:4] = '{
    {4'd0, 5'd15}, {4'd3, 5'd12}, {4'd7, 5'd8}, {4'd11, 5'd4}, {4'd15, 5'd1}
  };

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic setup(input logic en, input logic dma, input logic wr, input logic [3:0] f);
    cfg_fifo_en = en; cfg_dma_mode = dma; cfg_dir_wr = wr; cfg_thresh = f;
    exec_start = 1'b1;
    cyc();
    exec_start = 1'b0;
  endtask

  task automatic dev_push(input logic [7:0] d, input logic last);
    dev_in_valid = 1'b1; dev_in_data = d; sector_last = last;
    cyc();
    dev_in_valid = 1'b0; sector_last = 1'b0;
  endtask

  task automatic dev_pop();
    dev_out_ready = 1'b1;
    cyc();
    dev_out_ready = 1'b0;
  endtask

  task automatic host_wr(input logic [7:0] d, input logic last, input logic ack);
    host_wr_stb = 1'b1; host_wdata = d; xfer_last = last; dma_ack = ack;
    cyc();
    host_wr_stb = 1'b0; xfer_last = 1'b0; dma_ack = 1'b0;
  endtask

  task automatic host_rd(input logic last);
    host_rd_stb = 1'b1; xfer_last = last;
    cyc();
    host_rd_stb = 1'b0; xfer_last = 1'b0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk({irq, rqm, dma_req, result_phase, ovr_flag, udr_flag, dev_out_valid}, 0, "R1 reset outputs");

    // Table: read-direction trigger sweep
    for (int v = 0; v < 5; v++) begin
      logic [3:0] fld;
      logic [4:0] lvl;
      fld = RD_VEC[v][8:5];
      lvl = RD_VEC[v][4:0];
      setup(1'b1, 1'b0, 1'b0, fld);
      for (int k = 1; k <= 16; k++) begin
        dev_push(8'(v * 16 + k), 1'b0);
        chk(irq, (k >= lvl), $sformatf("R2 trigger fld=%0d k=%0d", fld, k));
        chk(rqm, irq, "R7 rqm follows irq");
      end
      chk(dev_in_ready, 0, "R2 full stops dev_in");
      chk(dma_req, 0, "R7 no dma_req in irq mode");
      for (int k = 16; k >= 1; k--) begin
        chk(host_rdata, 8'(v * 16 + 17 - k), "R13 read order");
        host_rd(1'b0);
        chk(irq, (k - 1 != 0), $sformatf("R3 hold until empty k=%0d", k - 1));
      end
    end

    // R4 sector flush below trigger (field 3 -> trigger 12)
    setup(1'b1, 1'b0, 1'b0, 4'd3);
    dev_push(8'h01, 1'b0);
    dev_push(8'h02, 1'b0);
    chk(irq, 0, "R4 below trigger");
    dev_push(8'h03, 1'b1);
    chk(irq, 1, "R4 sector end raises");
    host_rd(1'b0); host_rd(1'b0);
    chk(irq, 1, "R4 held while draining");
    host_rd(1'b0);
    chk(irq, 0, "R3 drop at empty after flush");

    // R6 disabled FIFO, read direction
    setup(1'b0, 1'b0, 1'b0, 4'd7);
    chk(irq, 0, "R6 idle before byte");
    dev_push(8'hA1, 1'b0);
    chk(irq, 1, "R6 per-byte request");
    chk(dev_in_ready, 0, "R6 single-byte store full");
    host_rd(1'b0);
    chk(irq, 0, "R6 drop after read");
    chk(dev_in_ready, 1, "R6 space again");

    // R6 disabled FIFO, write direction
    setup(1'b0, 1'b0, 1'b1, 4'd7);
    chk(irq, 1, "R6 write request on start");
    host_wr(8'hB1, 1'b0, 1'b0);
    chk(irq, 0, "R6 drop after one write");
    host_wr(8'hB2, 1'b0, 1'b0);
    chk(ovr_flag, 1, "R12 overrun in single-byte store");
    chk(dev_out_data, 8'hB1, "R12 dropped write leaves data");
    dev_pop();
    chk(irq, 1, "R6 request back after drain");
    chk(dev_out_valid, 0, "R12 no extra byte stored");

    // R5 write direction, field 3 -> refill at 4
    setup(1'b1, 1'b0, 1'b1, 4'd3);
    chk(ovr_flag, 0, "R12 exec_start clears overrun");
    chk(irq, 1, "R5 raise on start");
    chk(rqm, 1, "R7 rqm with irq");
    for (int k = 1; k <= 16; k++) begin
      host_wr(8'(8'h40 + k), 1'b0, 1'b0);
      chk(irq, (k < 16), $sformatf("R5 fill k=%0d", k));
    end
    host_wr(8'hEE, 1'b0, 1'b0);
    chk(ovr_flag, 1, "R12 overrun on full");
    for (int j = 1; j <= 16; j++) begin
      chk(dev_out_data, 8'(8'h40 + j), "R12 data intact after overrun");
      dev_pop();
      if (j == 11) chk(irq, 0, "R5 no refill above threshold");
      if (j == 12) chk(irq, 1, "R5 refill at threshold");
    end
    chk(dev_out_valid, 0, "R12 dropped byte absent");

    // R11 result phase after last host byte drained
    setup(1'b1, 1'b0, 1'b1, 4'd3);
    host_wr(8'h11, 1'b0, 1'b0);
    host_wr(8'h12, 1'b1, 1'b0);
    dev_pop();
    chk(result_phase, 0, "R11 not before empty");
    dev_pop();
    chk(result_phase, 1, "R11 raised when empty");

    // R8 DMA write terminal count
    setup(1'b1, 1'b1, 1'b1, 4'd3);
    chk(result_phase, 0, "R11 cleared by start");
    chk(dma_req, 1, "R7 dma_req on start");
    chk(irq, 0, "R7 irq idle in DMA");
    host_wr(8'h21, 1'b0, 1'b1);
    chk(dma_req, 1, "R8 still requesting");
    dma_tc = 1'b1; dma_ack = 1'b1;
    cyc();
    dma_tc = 1'b0; dma_ack = 1'b0;
    chk(dma_req, 0, "R8 tc with ack drops");
    dev_pop();
    chk(dma_req, 0, "R8 stays low after drain");
    chk(result_phase, 1, "R11 after tc and empty");

    // R9 DMA read, last byte by ack edge
    setup(1'b1, 1'b1, 1'b0, 4'd15);
    dev_push(8'h31, 1'b0);
    chk(dma_req, 1, "R9 request before last");
    xfer_last = 1'b1; dma_ack = 1'b1;
    cyc();
    xfer_last = 1'b0; dma_ack = 1'b0;
    chk(dma_req, 0, "R9 drop on ack edge");
    dev_push(8'h32, 1'b0);
    chk(dma_req, 0, "R9 held low for phase");

    // R9 DMA read, last byte by strobe with ack low
    setup(1'b1, 1'b1, 1'b0, 4'd15);
    dev_push(8'h41, 1'b0);
    dev_push(8'h42, 1'b0);
    host_rd(1'b1);
    chk(dma_req, 0, "R9 drop on strobe");
    chk(host_rdata, 8'h42, "R9 byte still held");

    // R10 non-DMA write, tc then both inactive
    setup(1'b1, 1'b0, 1'b1, 4'd3);
    host_wr(8'h51, 1'b0, 1'b0);
    chk(irq, 1, "R10 request before tc");
    dma_tc = 1'b1;
    cyc();
    dma_tc = 1'b0;
    chk(irq, 1, "R10 held while tc high");
    cyc();
    chk(irq, 0, "R10 cleared when both low");

    // R12 underrun
    setup(1'b1, 1'b0, 1'b0, 4'd3);
    host_rd(1'b0);
    chk(udr_flag, 1, "R12 underrun flag");
    chk(irq, 0, "R12 no request after empty read");
    dev_push(8'h5A, 1'b0);
    chk(host_rdata, 8'h5A, "R12 pointers intact");

    // R13 simultaneous push and pop, field 0 -> trigger 15
    setup(1'b1, 1'b0, 1'b0, 4'd0);
    for (int k = 1; k <= 5; k++) dev_push(8'(k), 1'b0);
    dev_in_valid = 1'b1; dev_in_data = 8'd6; host_rd_stb = 1'b1;
    cyc();
    dev_in_valid = 1'b0; host_rd_stb = 1'b0;
    chk(host_rdata, 8'd2, "R13 head advanced");
    for (int k = 7; k <= 15; k++) dev_push(8'(k), 1'b0);
    chk(irq, 0, "R13 count unchanged by push+pop");
    dev_push(8'd16, 1'b0);
    chk(irq, 1, "R13 trigger at 15");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule